// File: doc/BRIEF.md
# Receive Idle Timeout Detector

This block watches a receive path and flags when received characters have sat waiting without reaching the interrupt threshold for a programmed number of character times. A strobe arms a countdown each time a byte is stored in the receive FIFO. The countdown advances on a character-time tick from the baud-timing logic and is loaded from a 4-bit multiplier.

When the countdown runs out, the block raises a sticky timeout status flag and emits a one-cycle pulse that sets the receive interrupt source. It does this only if data is ready or the "assert on empty" control is set. Software clears the flag by writing a one to its clear bit.

The countdown is cancelled when the threshold-reached strobe arrives or the enable is cleared. FIFO storage and the interrupt register file sit outside this block.

Top module: `rx_idle_timeout`

## Requirements
- R1: After synchronous reset, `tmo_status` and `rx_src_set` are 0 and no countdown is pending.
- R2: While `tmo_en` is 0, no countdown is armed or advanced and `rx_src_set` stays 0. Clearing `tmo_en` cancels a pending countdown, so re-enabling does not resume it.
- R3: With multiplier M ≥ 1 taken at arming, expiry happens on the M-th `char_tick` cycle after the arming cycle. M = 0 expires on the first tick, as M = 1 does.
- R4: Every `byte_stored` strobe reloads the countdown from `tmo_mult`. A tick in the same cycle as `byte_stored` does not advance the countdown.
- R5: A `thresh_hit` strobe cancels the countdown. In a cycle with both `thresh_hit` and `byte_stored`, the cancel wins and nothing is armed.
- R6: An expiry sets status and pulse only if `data_ready` or `fire_when_empty` is 1 in the expiring cycle. An expiry without either still ends the countdown, and no set follows from it later.
- R7: `tmo_status` stays 1 until a cycle with `clr_wr`=1 and `clr_bit`=1. A write with `clr_bit`=0 leaves it unchanged. A set and a clear in the same cycle leave it at 1.
- R8: `rx_src_set` is high for exactly one clock. It rises together with `tmo_status` one clock after the expiring tick.
- R9: Changing `tmo_mult` while a countdown runs does not change its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmo_en | input | 1 | Timeout function enable |
| fire_when_empty | input | 1 | Allow expiry to set even with no data ready |
| tmo_mult | input | MULT_W | Timeout length in character times |
| byte_stored | input | 1 | Strobe: a byte entered the receive FIFO |
| data_ready | input | 1 | Level: receive data is available |
| thresh_hit | input | 1 | Strobe: receive threshold interrupt fired |
| char_tick | input | 1 | One-cycle pulse per character time |
| clr_wr | input | 1 | Write strobe to the status clear bit |
| clr_bit | input | 1 | Written value of the clear bit (1 clears) |
| tmo_status | output | 1 | Sticky timeout status |
| rx_src_set | output | 1 | One-cycle pulse to set the receive interrupt source |

## Verification
Directed runs separate the cases where the countdown length matters:
- multipliers of 0, 1 and 3;
- reloads by new bytes in mid-count;
- a multiplier change after arming.

Same-cycle collisions are driven on purpose to pin down each priority:
- byte store against tick;
- threshold against byte store;
- set against clear.

Runs with data absent and with the empty override set tell gated expiry from firing expiry. A long random stream mixing all strobes is then compared cycle by cycle against a bench model of the requirements.

// File: rtl/rxto_pkg.sv
package rxto_pkg;
  localparam int DEF_MULT_W = 4;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_STOP = 2'd1,
    ACT_LOAD = 2'd2,
    ACT_STEP = 2'd3
  } cd_act_e;
endpackage

// File: rtl/rxto_countdown.sv
module rxto_countdown
  import rxto_pkg::*;
#(
  parameter int MULT_W = DEF_MULT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              restart,
  input  logic              cancel,
  input  logic              tick,
  input  logic [MULT_W-1:0] mult,
  output logic              expire_o,
  output logic              armed_o
);
  localparam logic [MULT_W-1:0] ONE = MULT_W'(1);

  logic              armed_q;
  logic [MULT_W-1:0] cnt_q;
  logic              last_c;
  cd_act_e           act;

  assign last_c = (cnt_q <= ONE);

  always_comb begin
    act = ACT_HOLD;
    if (!en || cancel)             act = ACT_STOP;
    else if (restart)              act = ACT_LOAD;
    else if (armed_q && tick)      act = last_c ? ACT_STOP : ACT_STEP;
  end

  assign expire_o = en && !cancel && !restart && armed_q && tick && last_c;
  assign armed_o  = armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      unique case (act)
        ACT_STOP: armed_q <= 1'b0;
        ACT_LOAD: begin
          armed_q <= 1'b1;
          cnt_q   <= mult;
        end
        ACT_STEP: cnt_q <= cnt_q - ONE;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/rxto_flag.sv
module rxto_flag (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic gate_ok,
  input  logic clr,
  output logic status_o,
  output logic pulse_o
);
  logic fire_c;
  assign fire_c = expire && gate_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_o <= 1'b0;
      pulse_o  <= 1'b0;
    end else begin
      pulse_o <= fire_c;
      if (fire_c)   status_o <= 1'b1;
      else if (clr) status_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_idle_timeout.sv
module rx_idle_timeout
  import rxto_pkg::*;
#(
  parameter int MULT_W = DEF_MULT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tmo_en,
  input  logic              fire_when_empty,
  input  logic [MULT_W-1:0] tmo_mult,
  input  logic              byte_stored,
  input  logic              data_ready,
  input  logic              thresh_hit,
  input  logic              char_tick,
  input  logic              clr_wr,
  input  logic              clr_bit,
  output logic              tmo_status,
  output logic              rx_src_set
);
  logic expire_w;
  logic armed_w;

  rxto_countdown #(.MULT_W(MULT_W)) u_cd (
    .clk      (clk),
    .rst      (rst),
    .en       (tmo_en),
    .restart  (byte_stored),
    .cancel   (thresh_hit),
    .tick     (char_tick),
    .mult     (tmo_mult),
    .expire_o (expire_w),
    .armed_o  (armed_w)
  );

  rxto_flag u_flag (
    .clk      (clk),
    .rst      (rst),
    .expire   (expire_w),
    .gate_ok  (data_ready | fire_when_empty),
    .clr      (clr_wr & clr_bit),
    .status_o (tmo_status),
    .pulse_o  (rx_src_set)
  );
endmodule

// File: rtl/rx_idle_timeout_chk.sv
module rx_idle_timeout_chk (
  input logic clk,
  input logic rst,
  input logic tmo_en,
  input logic fire_when_empty,
  input logic byte_stored,
  input logic data_ready,
  input logic thresh_hit,
  input logic char_tick,
  input logic clr_wr,
  input logic clr_bit,
  input logic tmo_status,
  input logic rx_src_set
);
  AST_DIS_NO_SET: assert property (@(posedge clk) disable iff (rst)
    !tmo_en |=> !rx_src_set); // R2
  AST_NOTICK_NO_SET: assert property (@(posedge clk) disable iff (rst)
    !char_tick |=> !rx_src_set); // R3
  AST_BYTE_NO_SET: assert property (@(posedge clk) disable iff (rst)
    byte_stored |=> !rx_src_set); // R4
  AST_THR_NO_SET: assert property (@(posedge clk) disable iff (rst)
    thresh_hit |=> !rx_src_set); // R5
  AST_GATE: assert property (@(posedge clk) disable iff (rst)
    !(data_ready || fire_when_empty) |=> !rx_src_set); // R6
  AST_CLR: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && clr_bit) |=> (rx_src_set || !tmo_status)); // R7
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tmo_status && !(clr_wr && clr_bit)) |=> tmo_status); // R7
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rx_src_set |=> !rx_src_set); // R8
  AST_SET_STATUS: assert property (@(posedge clk) disable iff (rst)
    rx_src_set |-> tmo_status); // R8
endmodule

bind rx_idle_timeout rx_idle_timeout_chk u_chk (
  .clk             (clk),
  .rst             (rst),
  .tmo_en          (tmo_en),
  .fire_when_empty (fire_when_empty),
  .byte_stored     (byte_stored),
  .data_ready      (data_ready),
  .thresh_hit      (thresh_hit),
  .char_tick       (char_tick),
  .clr_wr          (clr_wr),
  .clr_bit         (clr_bit),
  .tmo_status      (tmo_status),
  .rx_src_set      (rx_src_set)
);

// File: tb/rx_idle_timeout_bench.sv
module rx_idle_timeout_bench;
  localparam int MW = 4;
  logic clk = 1'b0, rst = 1'b1;
  logic tmo_en = 0, few = 0, bs = 0, dr = 0, th = 0, tk = 0, cw = 0, cb = 0;
  logic [MW-1:0] mult = '0;
  logic tmo_status, rx_src_set;
  int n_vec = 0, n_bad = 0;

  // bench model state
  logic m_armed = 0, m_stat = 0, m_pulse = 0;
  int   m_cnt = 0;

  always #2 clk = ~clk;

  rx_idle_timeout u_rx_idle_timeout (
    .clk(clk), .rst(rst), .tmo_en(tmo_en), .fire_when_empty(few),
    .tmo_mult(mult), .byte_stored(bs), .data_ready(dr), .thresh_hit(th),
    .char_tick(tk), .clr_wr(cw), .clr_bit(cb),
    .tmo_status(tmo_status), .rx_src_set(rx_src_set));

  task automatic chk(input logic act, input logic exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void model_step();
    logic ex;
    ex = tmo_en && !th && !bs && m_armed && tk && (m_cnt <= 1);
    m_pulse = ex && (dr || few);
    if (m_pulse) m_stat = 1'b1;
    else if (cw && cb) m_stat = 1'b0;
    if (!tmo_en || th) m_armed = 1'b0;
    else if (bs) begin m_armed = 1'b1; m_cnt = int'(mult); end
    else if (m_armed && tk) begin
      if (m_cnt <= 1) m_armed = 1'b0; else m_cnt = m_cnt - 1;
    end
  endfunction

  // one clock: apply inputs, clock, compare against model
  task automatic cyc(input logic b, input logic t, input logic h,
                     input logic d, input logic w, input string tag);
    bs = b; tk = t; th = h; dr = d; cw = w; cb = w;
    @(posedge clk);
    model_step();
    #1;
    chk(rx_src_set, m_pulse, {tag, " pulse"});
    chk(tmo_status, m_stat, {tag, " status"});
    bs = 0; tk = 0; th = 0; cw = 0; cb = 0;
  endtask

  task automatic do_reset();
    rst = 1; @(posedge clk); @(posedge clk); #1;
    rst = 0; m_armed = 0; m_stat = 0; m_pulse = 0; m_cnt = 0;
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    chk(tmo_status, 1'b0, "R1 status");
    chk(rx_src_set, 1'b0, "R1 pulse");

    // R3: M=3 expires on third tick
    tmo_en = 1; mult = 4'd3;
    cyc(1, 0, 0, 1, 0, "R3 arm");
    cyc(0, 1, 0, 1, 0, "R3 t1"); chk(rx_src_set, 1'b0, "R3 t1");
    cyc(0, 1, 0, 1, 0, "R3 t2"); chk(rx_src_set, 1'b0, "R3 t2");
    cyc(0, 1, 0, 1, 0, "R3 t3"); chk(rx_src_set, 1'b1, "R3 expiry");
    cyc(0, 0, 0, 1, 0, "R8 next"); chk(rx_src_set, 1'b0, "R8 one cycle");
    chk(tmo_status, 1'b1, "R7 sticky");
    // R7: clear with bit 0 ignored, then real clear
    bs = 0; cw = 1; cb = 0; @(posedge clk); #1; cw = 0;
    n_vec++; if (tmo_status !== 1'b1) begin n_bad++; $display("FAIL R7: got %b expected 1", tmo_status); end
    cyc(0, 0, 0, 0, 1, "R7 clear"); chk(tmo_status, 1'b0, "R7 cleared");

    // R3: M=0 expires on first tick
    mult = 4'd0;
    cyc(1, 0, 0, 1, 0, "R3 m0 arm");
    cyc(0, 1, 0, 1, 0, "R3 m0"); chk(rx_src_set, 1'b1, "R3 m0 first tick");
    cyc(0, 0, 0, 0, 1, "R7 clr");

    // R4: byte with tick reloads
    mult = 4'd2;
    cyc(1, 0, 0, 1, 0, "R4 arm");
    cyc(0, 1, 0, 1, 0, "R4 t1");
    cyc(1, 1, 0, 1, 0, "R4 reload"); chk(rx_src_set, 1'b0, "R4 reload no fire");
    cyc(0, 1, 0, 1, 0, "R4 t1b"); chk(rx_src_set, 1'b0, "R4 after reload");
    cyc(0, 1, 0, 1, 0, "R4 t2b"); chk(rx_src_set, 1'b1, "R4 expiry");
    cyc(0, 0, 0, 0, 1, "R7 clr");

    // R5: threshold wins over byte
    cyc(1, 0, 1, 1, 0, "R5 both");
    repeat (4) cyc(0, 1, 0, 1, 0, "R5 ticks");
    chk(tmo_status, 1'b0, "R5 nothing armed");

    // R2: disable cancels
    cyc(1, 0, 0, 1, 0, "R2 arm");
    tmo_en = 0; cyc(0, 0, 0, 1, 0, "R2 off");
    tmo_en = 1; repeat (4) cyc(0, 1, 0, 1, 0, "R2 ticks");
    chk(tmo_status, 1'b0, "R2 cancelled");

    // R6: gated, then fire_when_empty
    mult = 4'd1;
    cyc(1, 0, 0, 0, 0, "R6 arm");
    cyc(0, 1, 0, 0, 0, "R6 gated"); chk(rx_src_set, 1'b0, "R6 gated");
    cyc(0, 1, 0, 1, 0, "R6 after"); chk(rx_src_set, 1'b0, "R6 ended");
    few = 1;
    cyc(1, 0, 0, 0, 0, "R6 arm2");
    cyc(0, 1, 0, 0, 0, "R6 empty"); chk(rx_src_set, 1'b1, "R6 empty fires");
    few = 0;
    // R7: set and clear together keep status
    cyc(0, 0, 0, 0, 1, "R7 clr");
    cyc(1, 0, 0, 1, 0, "R7 arm");
    cyc(0, 1, 0, 1, 1, "R7 race"); chk(tmo_status, 1'b1, "R7 set beats clear");
    cyc(0, 0, 0, 0, 1, "R7 clr");

    // R9: multiplier change after arming
    mult = 4'd2;
    cyc(1, 0, 0, 1, 0, "R9 arm");
    mult = 4'd9;
    cyc(0, 1, 0, 1, 0, "R9 t1");
    cyc(0, 1, 0, 1, 0, "R9 t2"); chk(rx_src_set, 1'b1, "R9 length kept");
    cyc(0, 0, 0, 0, 1, "R7 clr");

    // random mix, checked against model
    for (int i = 0; i < 20000; i++) begin
      tmo_en = ($urandom % 16) != 0;
      few    = ($urandom % 8) == 0;
      mult   = MW'($urandom % 6);
      cyc(($urandom % 6) == 0, ($urandom % 2) == 0, ($urandom % 20) == 0,
          ($urandom % 4) != 0, ($urandom % 10) == 0, "R8 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule